// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the byte-level control engine of an I2C master. Software writes a command word that carries up to five requests: address phase (start), transmit, receive, receive-last and stop. The block runs the requested phases one after another in a fixed order. Each phase is one operation on an abstract byte-level bus port, using a request/done handshake. The block never touches SCL or SDA timing. A bus agent below it turns each operation into wire activity and returns ACK/NAK and the received byte.

As each phase finishes, the block clears its command bit and updates a 4-bit transfer-state code. It also sets sticky status flags, which software clears by writing ones. After the last phase of a command write, a one-cycle completion pulse lets an interrupt stage sample the flags. A command write is taken only when the master is enabled and the engine is idle.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset the status word is zero, all flags are zero, and neither the bus request nor the completion pulse is asserted.
- R2: A command write is ignored unless master enable is high and the engine is idle. An ignored write leaves the command bits unchanged and issues no bus operation.
- R3: An accepted write replaces status bits 15:0 with the written word. Command bits are start=0, transmit=1, receive=3, receive-last=4 and stop=5; the other written bits are kept as written. Bit 16 reads bus-busy and bits 22:19 read the transfer state; all other status bits read zero.
- R4: The phases run in the order address, transmit, receive, stop. Bus operation codes are 0 start-with-address, 1 send byte, 2 receive byte, 3 send NACK and 4 end transfer.
- R5: The address phase sets the state to 0xA when state bit 3 was set, and to 0x9 otherwise. It sends tx_byte[7:1] as the address and tx_byte[0] as the direction. An acknowledge sets flag 0 and a NAK sets flag 1. The address phase clears both the start and transmit bits.
- R6: After an acknowledged address, busy is set and the state becomes 0x8. After a NAK on the address, busy is cleared and the sequence ends at once: the state stays at 0x9 or 0xA, and the receive, receive-last and stop bits stay set.
- R7: The transmit phase sets the state to 0xC and sends tx_byte. It then sets flag 0 on ACK, or on NAK sets flag 1, issues an end-transfer operation and clears busy. It clears the transmit bit and leaves the state at 0x8.
- R8: The receive phase runs when the receive or receive-last bit is set and flag 2 (receive done) is clear. It sets the state to 0xE, stores the received byte on rx_byte and sets flag 2. When receive-last is set, it also issues a send-NACK operation. It then clears both receive bits and leaves the state at 0x8. If flag 2 is already set, the phase is skipped and both receive bits stay set.
- R9: Stop when state bit 3 is clear sets flag 4 (abnormal) and issues no bus operation. Stop when state bit 3 is set issues an end-transfer operation, sets flag 3 and clears busy. In both cases the stop bit is cleared and the state becomes 0x0.
- R10: seq_done is high for exactly one cycle after the last phase of each accepted write, and the engine is then idle.
- R11: Writing a one to a bit of flag_clr clears that flag; flags whose clear bit is zero are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | Master function enable |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 16 | Command word |
| tx_byte | input | 8 | Address byte or data byte to send |
| flag_clr | input | 5 | Write-one-to-clear for the status flags |
| status_word | output | 32 | Command bits, busy and transfer state |
| flags | output | 5 | ACK, NAK, receive done, normal stop, abnormal stop |
| rx_byte | output | 8 | Last received byte |
| seq_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus operation request, held until bus_done |
| bus_op | output | 3 | Bus operation code |
| bus_addr | output | 7 | Target address for a start operation |
| bus_rd | output | 1 | Direction for a start operation (1 = read) |
| bus_wdata | output | 8 | Byte for a send operation |
| bus_done | input | 1 | Bus operation complete |
| bus_nak | input | 1 | Start or send was not acknowledged |
| bus_rdata | input | 8 | Byte returned by a receive operation |

## Verification
The bench sweeps every combination of the five command bits against three prior conditions (idle, active, and active with receive-done already set) and against ACK or NAK on the address and on the data byte. It compares the exact operation sequence, the flags, the state code and the leftover command bits with an arithmetic model. Several faults show up this way. A design that runs transmit in the same write as start sends an extra byte. One that keeps going after an address NAK issues stray receive or end operations. Picking 0x9 where 0xA is due, or the reverse, shows in the state field. A design that fails to gate receive on the done flag receives twice. Writes while disabled or while a sequence is running must not change anything, and a stop outside the active state must raise the abnormal flag without touching the bus.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CMD_W  = 16;
  localparam int ST_W   = 4;
  localparam int NFLAG  = 5;
  localparam int STAT_W = 32;
  localparam int ST_LSB = 19;
  localparam int BUSY_BIT = 16;
  localparam int PAD_HI = STAT_W - ST_LSB - ST_W;
  localparam int PAD_LO = ST_LSB - BUSY_BIT - 1;

  // command bit positions
  localparam int CB_START = 0;
  localparam int CB_TX    = 1;
  localparam int CB_RX    = 3;
  localparam int CB_LAST  = 4;
  localparam int CB_STOP  = 5;

  // flag positions
  localparam int FL_ACK  = 0;
  localparam int FL_NAK  = 1;
  localparam int FL_RXD  = 2;
  localparam int FL_STOP = 3;
  localparam int FL_ABN  = 4;

  // transfer state codes
  localparam logic [ST_W-1:0] TS_IDLE   = 4'h0;
  localparam logic [ST_W-1:0] TS_ACTIVE = 4'h8;
  localparam logic [ST_W-1:0] TS_START  = 4'h9;
  localparam logic [ST_W-1:0] TS_RSTART = 4'hA;
  localparam logic [ST_W-1:0] TS_STOP   = 4'hB;
  localparam logic [ST_W-1:0] TS_TXD    = 4'hC;
  localparam logic [ST_W-1:0] TS_RXD    = 4'hE;

  typedef enum logic [3:0] {
    PH_IDLE, PH_PICK, PH_START, PH_TX, PH_TXEND, PH_RX, PH_NACK, PH_STOP, PH_DONE
  } phase_t;

  typedef enum logic [2:0] {
    OP_START = 3'd0, OP_SEND = 3'd1, OP_RECV = 3'd2, OP_NACK = 3'd3, OP_END = 3'd4
  } bus_op_t;
endpackage

// File: rtl/i2c_seq_pick.sv
module i2c_seq_pick
  import i2c_seq_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  input  logic             rx_done,
  output phase_t           nxt
);
  // fixed priority: address, transmit, receive, stop
  always_comb begin
    if (cmd[CB_START])                                  nxt = PH_START;
    else if (cmd[CB_TX])                                nxt = PH_TX;
    else if ((cmd[CB_RX] || cmd[CB_LAST]) && !rx_done)  nxt = PH_RX;
    else if (cmd[CB_STOP])                              nxt = PH_STOP;
    else                                                nxt = PH_DONE;
  end
endmodule

// File: rtl/i2c_seq_flags.sv
module i2c_seq_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)          flags[i] <= 1'b0;
      else if (set[i])  flags[i] <= 1'b1;
      else if (clr[i])  flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  master_en,
  input  logic                  cmd_we,
  input  logic [CMD_W-1:0]      cmd_wdata,
  input  logic [BYTE_W-1:0]     tx_byte,
  input  logic [NFLAG-1:0]      flag_clr,
  output logic [STAT_W-1:0]     status_word,
  output logic [NFLAG-1:0]      flags,
  output logic [BYTE_W-1:0]     rx_byte,
  output logic                  seq_done,
  output logic                  bus_req,
  output logic [2:0]            bus_op,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic                  bus_rd,
  output logic [BYTE_W-1:0]     bus_wdata,
  input  logic                  bus_done,
  input  logic                  bus_nak,
  input  logic [BYTE_W-1:0]     bus_rdata
);
  phase_t            phase;
  phase_t            pick;
  logic [CMD_W-1:0]  cmd;
  logic [ST_W-1:0]   tstate;
  logic              busy;
  logic [NFLAG-1:0]  flag_set;
  logic              wr_ok;
  logic              fin;

  assign wr_ok = cmd_we && master_en && (phase == PH_IDLE);
  assign fin   = bus_req && bus_done;

  i2c_seq_pick u_pick (
    .cmd     (cmd),
    .rx_done (flags[FL_RXD]),
    .nxt     (pick)
  );

  i2c_seq_flags #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set   (flag_set),
    .clr   (flag_clr),
    .flags (flags)
  );

  always_comb begin
    flag_set = '0;
    if (phase == PH_PICK && pick == PH_STOP && !tstate[3]) flag_set[FL_ABN] = 1'b1;
    if (fin) begin
      case (phase)
        PH_START, PH_TX: begin
          if (bus_nak) flag_set[FL_NAK] = 1'b1;
          else         flag_set[FL_ACK] = 1'b1;
        end
        PH_RX:   flag_set[FL_RXD]  = 1'b1;
        PH_STOP: flag_set[FL_STOP] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cmd     <= '0;
      tstate  <= TS_IDLE;
      busy    <= 1'b0;
      rx_byte <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (wr_ok) begin
          cmd   <= cmd_wdata;
          phase <= PH_PICK;
        end
        PH_PICK: begin
          phase <= pick;
          case (pick)
            PH_START: tstate <= tstate[3] ? TS_RSTART : TS_START;
            PH_TX:    tstate <= TS_TXD;
            PH_RX:    tstate <= TS_RXD;
            PH_STOP: begin
              if (tstate[3]) tstate <= TS_STOP;
              else begin
                cmd[CB_STOP] <= 1'b0;
                tstate       <= TS_IDLE;
                phase        <= PH_DONE;
              end
            end
            default: ;
          endcase
        end
        PH_START: if (fin) begin
          cmd[CB_START] <= 1'b0;
          cmd[CB_TX]    <= 1'b0;
          if (bus_nak) begin
            busy  <= 1'b0;
            phase <= PH_DONE;
          end else begin
            busy   <= 1'b1;
            tstate <= TS_ACTIVE;
            phase  <= PH_PICK;
          end
        end
        PH_TX: if (fin) begin
          cmd[CB_TX] <= 1'b0;
          tstate     <= TS_ACTIVE;
          phase      <= bus_nak ? PH_TXEND : PH_PICK;
        end
        PH_TXEND: if (fin) begin
          busy  <= 1'b0;
          phase <= PH_PICK;
        end
        PH_RX: if (fin) begin
          rx_byte <= bus_rdata;
          if (cmd[CB_LAST]) phase <= PH_NACK;
          else begin
            cmd[CB_RX] <= 1'b0;
            tstate     <= TS_ACTIVE;
            phase      <= PH_PICK;
          end
        end
        PH_NACK: if (fin) begin
          cmd[CB_RX]   <= 1'b0;
          cmd[CB_LAST] <= 1'b0;
          tstate       <= TS_ACTIVE;
          phase        <= PH_PICK;
        end
        PH_STOP: if (fin) begin
          busy          <= 1'b0;
          cmd[CB_STOP]  <= 1'b0;
          tstate        <= TS_IDLE;
          phase         <= PH_DONE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req = 1'b1;
    bus_op  = OP_END;
    case (phase)
      PH_START: bus_op = OP_START;
      PH_TX:    bus_op = OP_SEND;
      PH_RX:    bus_op = OP_RECV;
      PH_NACK:  bus_op = OP_NACK;
      PH_TXEND, PH_STOP: bus_op = OP_END;
      default:  bus_req = 1'b0;
    endcase
  end

  assign bus_addr    = tx_byte[BYTE_W-1:1];
  assign bus_rd      = tx_byte[0];
  assign bus_wdata   = tx_byte;
  assign seq_done    = (phase == PH_DONE);
  assign status_word = {{PAD_HI{1'b0}}, tstate, {PAD_LO{1'b0}}, busy, cmd};

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);

  // R2
  hold_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && !master_en) |=> $stable(cmd));

  // R8
  rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_op == OP_RECV) |-> !flags[FL_RXD]);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[FL_STOP]) |-> (tstate == TS_IDLE && !busy));
endmodule

// File: tb/i2c_cmd_seq_bench.sv
module i2c_cmd_seq_bench;
  import i2c_seq_pkg::*;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1, master_en = 0, cmd_we = 0;
  logic [15:0] cmd_wdata = '0;
  logic [7:0]  tx_byte = '0;
  logic [4:0]  flag_clr = '0;
  logic [31:0] status_word;
  logic [4:0]  flags;
  logic [7:0]  rx_byte, bus_wdata, bus_rdata = '0;
  logic        seq_done, bus_req, bus_rd, bus_done = 0, bus_nak = 0;
  logic [2:0]  bus_op;
  logic [6:0]  bus_addr;

  logic rsp_anak = 0, rsp_snak = 0;
  logic [7:0] rsp_data = 8'h00;
  logic [2:0] log_op [256];
  logic [7:0] log_byte [256];
  int tot = 0;
  int nchk = 0, nfail = 0;

  logic [2:0]  e_op [8];
  int          e_n;
  logic [15:0] e_cmd;
  logic [3:0]  e_st;
  logic        e_bz;
  logic [4:0]  e_fl;

  always #(CLK_P/2) clk = ~clk;

  i2c_cmd_seq u_i2c_cmd_seq (.*);

  // byte-level bus agent
  always @(negedge clk) begin
    if (rst) bus_done = 0;
    else if (bus_done) bus_done = 0;
    else if (bus_req) begin
      bus_done = 1;
      bus_nak = (bus_op == OP_START) ? rsp_anak : (bus_op == OP_SEND) ? rsp_snak : 1'b0;
      bus_rdata = rsp_data;
      log_op[tot % 256] = bus_op;
      log_byte[tot % 256] = (bus_op == OP_START) ? {bus_addr, bus_rd} : bus_wdata;
      tot = tot + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail + 1);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic write_cmd(input logic [15:0] v);
    @(negedge clk);
    cmd_we = 1; cmd_wdata = v;
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic wait_done();
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!seq_done && k < 200);
    chk("R10 completion pulse seen", {31'b0, seq_done}, 32'd1);
  endtask

  task automatic clear_flags(input logic [4:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = '0;
  endtask

  task automatic push(input logic [2:0] op);
    e_op[e_n] = op;
    e_n++;
  endtask

  // requirement model
  task automatic model(input int prior, input logic [15:0] wv, input logic an, input logic sn);
    logic early;
    e_cmd = wv; e_n = 0; early = 0;
    e_st = (prior == 0) ? 4'h0 : 4'h8;
    e_bz = (prior != 0);
    e_fl = (prior == 2) ? 5'b00100 : 5'b00000;
    if (e_cmd[0]) begin
      e_st = e_st[3] ? 4'hA : 4'h9;
      push(OP_START);
      e_cmd[0] = 0; e_cmd[1] = 0;
      if (an) begin e_fl[1] = 1; e_bz = 0; early = 1; end
      else begin e_fl[0] = 1; e_bz = 1; e_st = 4'h8; end
    end
    if (!early) begin
      if (e_cmd[1]) begin
        push(OP_SEND);
        if (sn) begin e_fl[1] = 1; push(OP_END); e_bz = 0; end
        else e_fl[0] = 1;
        e_cmd[1] = 0; e_st = 4'h8;
      end
      if ((e_cmd[3] || e_cmd[4]) && !e_fl[2]) begin
        push(OP_RECV); e_fl[2] = 1;
        if (e_cmd[4]) push(OP_NACK);
        e_cmd[3] = 0; e_cmd[4] = 0; e_st = 4'h8;
      end
      if (e_cmd[5]) begin
        if (!e_st[3]) e_fl[4] = 1;
        else begin push(OP_END); e_fl[3] = 1; e_bz = 0; end
        e_cmd[5] = 0; e_st = 4'h0;
      end
    end
  endtask

  task automatic prep(input int prior);
    do_reset();
    master_en = 1; rsp_anak = 0; rsp_snak = 0; tx_byte = 8'h20;
    if (prior >= 1) begin
      write_cmd(16'h0001); wait_done();
      if (prior == 2) begin
        write_cmd(16'h0008); wait_done();
        clear_flags(5'b11011);
        chk("R11 selective flag clear", {27'b0, flags}, 32'h4);
      end else begin
        clear_flags(5'b11111);
        chk("R11 flag clear", {27'b0, flags}, 32'h0);
      end
    end
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 status word", status_word, 32'h0);
    chk("R1 flags", {27'b0, flags}, 32'h0);
    chk("R1 no request", {31'b0, bus_req}, 32'h0);
    chk("R1 no done", {31'b0, seq_done}, 32'h0);

    // R2 write ignored while master disabled
    master_en = 0;
    write_cmd(16'h0021);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R2 no done when disabled", {31'b0, seq_done}, 32'h0);
      chk("R2 no bus op when disabled", {31'b0, bus_req}, 32'h0);
    end
    chk("R2 command bits unchanged", {16'b0, status_word[15:0]}, 32'h0);

    // R2 write ignored while a sequence runs
    master_en = 1; rsp_anak = 0; tx_byte = 8'h40;
    begin
      int b = tot;
      @(negedge clk); cmd_we = 1; cmd_wdata = 16'h0021;
      @(negedge clk); cmd_wdata = 16'h0002;
      @(negedge clk); cmd_we = 0;
      wait_done();
      chk("R2 busy write dropped: op count", tot - b, 32'd2);
      chk("R2 busy write dropped: command", {16'b0, status_word[15:0]}, 32'h0);
      chk("R9 normal stop flag", {27'b0, flags}, 32'h9);
    end

    // sweep all command combinations against prior state and responses
    for (int prior = 0; prior < 3; prior++)
      for (int cb = 0; cb < 32; cb++)
        for (int r = 0; r < 4; r++) begin
          logic [15:0] wv;
          int base;
          prep(prior);
          wv = 16'hA404 | {10'b0, cb[4], cb[3], cb[2], 1'b0, cb[1], cb[0]};
          rsp_anak = r[0]; rsp_snak = r[1];
          tx_byte = 8'(8'h5B + cb * 7 + r);
          rsp_data = 8'(8'hC3 ^ cb);
          model(prior, wv, r[0], r[1]);
          base = tot;
          write_cmd(wv);
          wait_done();
          chk("R3 command bits", {16'b0, status_word[15:0]}, {16'b0, e_cmd});
          chk("R5 R6 R7 R9 state field", {28'b0, status_word[22:19]}, {28'b0, e_st});
          chk("R6 busy bit", {31'b0, status_word[16]}, {31'b0, e_bz});
          chk("R3 unused status bits", status_word & 32'hFF86_0000, 32'h0);
          chk("R5 R7 R8 R9 flags", {27'b0, flags}, {27'b0, e_fl});
          chk("R4 operation count", tot - base, e_n);
          for (int i = 0; i < 8; i++)
            if (i < e_n && i < tot - base) begin
              chk("R4 operation order", {29'b0, log_op[(base + i) % 256]}, {29'b0, e_op[i]});
              if (e_op[i] == OP_START || e_op[i] == OP_SEND)
                chk("R5 R7 address or data byte", {24'b0, log_byte[(base + i) % 256]}, {24'b0, tx_byte});
              if (e_op[i] == OP_RECV)
                chk("R8 received byte", {24'b0, rx_byte}, {24'b0, rsp_data});
            end
          @(negedge clk);
          chk("R10 pulse lasts one cycle", {31'b0, seq_done}, 32'h0);
        end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule